// File: doc/BRIEF.md
# Keyboard and Display Port Interface

This block lets a processor exchange characters with a keyboard source and a display sink through four registers placed in the ordinary address space. Memory and I/O share one address space and one pair of read and write strobes, so software reaches the port with plain loads and stores. An address decoder compares the upper address bits against a base parameter. Only on a match does the port answer or change state.

Each direction is a small two-state machine. The input channel has the states `IN_EMPTY` and `IN_FULL`. It moves `IN_EMPTY -> IN_FULL` when a keyboard character is accepted. It moves `IN_FULL -> IN_EMPTY` when the processor reads the keyboard data register. It stays in `IN_FULL` when a read and a new character meet in the same cycle, and it also stays in `IN_FULL` when a character arrives without a read; that character is dropped and the overrun flag is set. The output channel has the states `OUT_EMPTY` and `OUT_FULL`. It moves `OUT_EMPTY -> OUT_FULL` on a processor write of a character. It moves `OUT_FULL -> OUT_EMPTY` when the display side completes its valid/ready handshake.

Two enable bits gate each device's handshake and its interrupt request. The single interrupt output is the OR of the two gated requests.

Top module: `kbd_disp_port`

## Requirements
- R1: The port responds only when `bus_addr[15:4]` equals `BASE_ADDR[15:4]` (default 0x0F4x). `bus_addr[3:2]` selects the register: 0 is keyboard data, 1 (offset 4) is display data, 2 (offset 8) is status, 3 (offset 12) is control. On a miss, `bus_rdata` is 0, writes change nothing, and reads have no side effect.
- R2: After reset, status reads 0x02, control reads 0, and `irq`, `dp_valid` and `kb_ready` are all 0.
- R3: While the keyboard enable (control bit 0) is 1, `kb_ready` is 1. A handshake (`kb_valid` and `kb_ready`) in `IN_EMPTY` stores `kb_char` and sets status bit 0 (input ready).
- R4: A read of offset 0 returns the held character in bits 7:0 and clears status bit 0. If a new character is accepted in the same cycle as the read, that character is loaded, bit 0 stays 1, and no overrun is recorded.
- R5: A character accepted while status bit 0 is 1, with no read of offset 0 in that cycle, is dropped and sets status bit 4 (overrun). The overrun bit stays set until a write to status with data bit 4 equal to 1.
- R6: While the keyboard enable is 0, `kb_ready` is 0 and no character is captured.
- R7: A write to offset 4 while status bit 1 (output ready) is 1 stores the data byte and clears bit 1. A write while bit 1 is 0 is ignored.
- R8: `dp_valid` is 1 exactly while a character is held and the display enable (control bit 1) is 1. `dp_char` stays stable while the character is held. A cycle with `dp_valid` and `dp_ready` both 1 empties the register and sets status bit 1.
- R9: Status bit 2 equals bit 0 AND the keyboard enable. Status bit 3 equals bit 1 AND the display enable. `irq` is the OR of bits 2 and 3.
- R10: Control bits 1:0 are read/write and hold the display and keyboard enables. All other control bits read 0.
- R11: A write to offset 0 has no effect, and a read of offset 4 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Byte address from the processor |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on the current address |
| kb_valid | input | 1 | Keyboard side offers a character |
| kb_char | input | 8 | Keyboard character |
| kb_ready | output | 1 | Port accepts a keyboard character |
| dp_valid | output | 1 | Port offers a character to the display |
| dp_char | output | 8 | Display character |
| dp_ready | input | 1 | Display side takes the character |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets four corner cases.
- A read and a new keyboard character in the same cycle. A design that clears the flag after loading would lose that character, or would flag a false overrun.
- A second keyboard character before the first is read. This must keep the first character and raise the sticky overrun bit; a wrong design would overwrite the first character or let the overrun bit clear by itself.
- A second write to a full output register and a character written while the display is disabled. A faulty port would corrupt the pending character or present it to the display too early.
- Address misses and accesses of the wrong kind to the read-only and write-only offsets. An incomplete decoder would alias into the port or leak the held character.

// File: rtl/kdp_pkg.sv
package kdp_pkg;

    typedef enum logic [1:0] {
        SEL_KIN  = 2'd0,
        SEL_DOUT = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CTRL = 2'd3
    } reg_sel_e;

    typedef enum logic {
        IN_EMPTY = 1'b0,
        IN_FULL  = 1'b1
    } in_state_e;

    typedef enum logic {
        OUT_EMPTY = 1'b0,
        OUT_FULL  = 1'b1
    } out_state_e;

    localparam int ST_IN_RDY  = 0;
    localparam int ST_OUT_RDY = 1;
    localparam int ST_KREQ    = 2;
    localparam int ST_DREQ    = 3;
    localparam int ST_OVR     = 4;
    localparam int CT_KEN     = 0;
    localparam int CT_DEN     = 1;

endpackage

// File: rtl/kdp_decode.sv
module kdp_decode
    import kdp_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [15:0]     BASE_ADDR = 16'h0F40
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output logic              hit,
    output reg_sel_e          sel,
    output logic              rd_kin,
    output logic              wr_dout,
    output logic              wr_stat,
    output logic              wr_ctrl
);
    localparam int TAG_LSB = 4;
    localparam logic [ADDR_W-1:0] BASE_W = ADDR_W'(BASE_ADDR);

    logic unused_low;
    assign unused_low = ^addr[1:0];

    always_comb begin
        hit     = (addr[ADDR_W-1:TAG_LSB] == BASE_W[ADDR_W-1:TAG_LSB]);
        sel     = reg_sel_e'(addr[3:2]);
        rd_kin  = 1'b0;
        wr_dout = 1'b0;
        wr_stat = 1'b0;
        wr_ctrl = 1'b0;
        if (hit) begin
            unique case (sel)
                SEL_KIN:  rd_kin  = rd;
                SEL_DOUT: wr_dout = wr;
                SEL_STAT: wr_stat = wr;
                SEL_CTRL: wr_ctrl = wr;
            endcase
        end
    end
endmodule

// File: rtl/kdp_in_chan.sv
module kdp_in_chan
    import kdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              kb_valid,
    input  logic [DATA_W-1:0] kb_char,
    output logic              kb_ready,
    input  logic              rd_take,
    input  logic              ovr_clr,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              overrun
);
    in_state_e state_q, state_d;
    logic      xfer;
    logic      load;
    logic      drop;

    assign kb_ready = en;
    assign xfer     = kb_valid && en;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= IN_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions and per-state outputs
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        drop    = 1'b0;
        unique case (state_q)
            IN_EMPTY: begin
                if (xfer) begin
                    load    = 1'b1;
                    state_d = IN_FULL;
                end
            end
            IN_FULL: begin
                if (rd_take && xfer) begin
                    load    = 1'b1;
                    state_d = IN_FULL;
                end else if (rd_take) begin
                    state_d = IN_EMPTY;
                end else if (xfer) begin
                    drop    = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data    <= '0;
            overrun <= 1'b0;
        end else begin
            if (load) data <= kb_char;
            if (drop)         overrun <= 1'b1;
            else if (ovr_clr) overrun <= 1'b0;
        end
    end

    assign full = (state_q == IN_FULL);
endmodule

// File: rtl/kdp_out_chan.sv
module kdp_out_chan
    import kdp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              wr_put,
    input  logic [DATA_W-1:0] wdata,
    output logic              dp_valid,
    output logic [DATA_W-1:0] dp_char,
    input  logic              dp_ready,
    output logic              full
);
    out_state_e state_q, state_d;
    logic       load;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= OUT_EMPTY;
        else        state_q <= state_d;
    end

    // Transitions and per-state outputs
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        dp_valid = 1'b0;
        unique case (state_q)
            OUT_EMPTY: begin
                if (wr_put) begin
                    load    = 1'b1;
                    state_d = OUT_FULL;
                end
            end
            OUT_FULL: begin
                dp_valid = en;
                if (en && dp_ready) state_d = OUT_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)    dp_char <= '0;
        else if (load) dp_char <= wdata;
    end

    assign full = (state_q == OUT_FULL);
endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port
    import kdp_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 8,
    parameter logic [15:0] BASE_ADDR = 16'h0F40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              kb_valid,
    input  logic [DATA_W-1:0] kb_char,
    output logic              kb_ready,
    output logic              dp_valid,
    output logic [DATA_W-1:0] dp_char,
    input  logic              dp_ready,
    output logic              irq
);
    localparam int ST_W = ST_OVR + 1;
    localparam int CT_W = CT_DEN + 1;

    logic           dec_hit;
    reg_sel_e       dec_sel;
    logic           rd_kin, wr_dout, wr_stat, wr_ctrl;
    logic           in_full, out_full, overrun;
    logic [DATA_W-1:0] in_data;
    logic [CT_W-1:0]   ctrl_q;
    logic [ST_W-1:0]   status;
    logic           ken, den;
    logic           unused_wd;

    assign unused_wd = ^{bus_wdata[DATA_W-1:ST_W], bus_wdata[ST_OVR-1:CT_W]};

    kdp_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr    (bus_addr),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .hit     (dec_hit),
        .sel     (dec_sel),
        .rd_kin  (rd_kin),
        .wr_dout (wr_dout),
        .wr_stat (wr_stat),
        .wr_ctrl (wr_ctrl)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata[CT_W-1:0];
    end
    assign ken = ctrl_q[CT_KEN];
    assign den = ctrl_q[CT_DEN];

    kdp_in_chan #(.DATA_W(DATA_W)) u_in (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (ken),
        .kb_valid (kb_valid),
        .kb_char  (kb_char),
        .kb_ready (kb_ready),
        .rd_take  (rd_kin),
        .ovr_clr  (wr_stat && bus_wdata[ST_OVR]),
        .full     (in_full),
        .data     (in_data),
        .overrun  (overrun)
    );

    kdp_out_chan #(.DATA_W(DATA_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (den),
        .wr_put   (wr_dout),
        .wdata    (bus_wdata),
        .dp_valid (dp_valid),
        .dp_char  (dp_char),
        .dp_ready (dp_ready),
        .full     (out_full)
    );

    always_comb begin
        status             = '0;
        status[ST_IN_RDY]  = in_full;
        status[ST_OUT_RDY] = !out_full;
        status[ST_KREQ]    = in_full && ken;
        status[ST_DREQ]    = !out_full && den;
        status[ST_OVR]     = overrun;
    end

    assign irq = status[ST_KREQ] || status[ST_DREQ];

    always_comb begin
        bus_rdata = '0;
        if (dec_hit && bus_rd) begin
            unique case (dec_sel)
                SEL_KIN:  bus_rdata = in_data;
                SEL_DOUT: bus_rdata = '0;
                SEL_STAT: bus_rdata = DATA_W'(status);
                SEL_CTRL: bus_rdata = DATA_W'(ctrl_q);
            endcase
        end
    end
endmodule

// File: rtl/kdp_checker.sv
module kdp_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_kin,
    input logic              wr_dout,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              kb_valid,
    input logic              kb_ready,
    input logic              in_full,
    input logic              overrun,
    input logic              out_full,
    input logic              dp_valid,
    input logic              dp_ready,
    input logic [DATA_W-1:0] dp_char,
    input logic              ken,
    input logic              den,
    input logic              irq
);
    a_r3_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (kb_valid && kb_ready) |=> in_full);

    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_kin && !(kb_valid && kb_ready)) |=> !in_full);

    a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_full && kb_valid && kb_ready && !rd_kin) |=> overrun);

    a_r6_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!ken && !in_full) |=> !in_full);

    a_r7_out_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dout && !out_full) |=> (out_full && dp_char == $past(bus_wdata)));

    a_r8_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && dp_ready) |=> !out_full);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_valid && !dp_ready) |=> (out_full && $stable(dp_char)));

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!ken && !den) |-> !irq);
endmodule

bind kbd_disp_port kdp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_kin    (rd_kin),
    .wr_dout   (wr_dout),
    .bus_wdata (bus_wdata),
    .kb_valid  (kb_valid),
    .kb_ready  (kb_ready),
    .in_full   (in_full),
    .overrun   (overrun),
    .out_full  (out_full),
    .dp_valid  (dp_valid),
    .dp_ready  (dp_ready),
    .dp_char   (dp_char),
    .ken       (ken),
    .den       (den),
    .irq       (irq)
);

// File: tb/tb_kbd_disp_port.sv
module tb_kbd_disp_port;
    localparam logic [15:0] A_KIN  = 16'h0F40;
    localparam logic [15:0] A_DOUT = 16'h0F44;
    localparam logic [15:0] A_STAT = 16'h0F48;
    localparam logic [15:0] A_CTRL = 16'h0F4C;
    localparam logic [15:0] A_MISS = 16'h0F50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        kb_valid = 1'b0;
    logic [7:0]  kb_char = '0;
    logic        kb_ready;
    logic        dp_valid;
    logic [7:0]  dp_char;
    logic        dp_ready = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    kbd_disp_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kb_valid(kb_valid), .kb_char(kb_char), .kb_ready(kb_ready),
        .dp_valid(dp_valid), .dp_char(dp_char), .dp_ready(dp_ready),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic kb_send(input logic [7:0] c);
        @(negedge clk);
        kb_char = c; kb_valid = 1'b1;
        @(negedge clk);
        kb_valid = 1'b0;
    endtask

    task automatic dp_take(output logic [7:0] c);
        @(negedge clk);
        c = dp_char; dp_ready = 1'b1;
        @(negedge clk);
        dp_ready = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(A_STAT, d);   chk("R2 status", d, 8'h02);
        bus_read(A_CTRL, d);   chk("R2 control", d, 8'h00);
        chk("R2 irq", irq, 0);
        chk("R2 dp_valid", dp_valid, 0);
        chk("R2 kb_ready", kb_ready, 0);
    endtask

    task automatic t_kb_disabled();
        logic [7:0] d;
        kb_send(8'h11);
        bus_read(A_STAT, d);   chk("R6 no capture", d, 8'h02);
        chk("R6 kb_ready low", kb_ready, 0);
    endtask

    task automatic t_enable();
        logic [7:0] d;
        bus_write(A_CTRL, 8'hFF);
        bus_read(A_CTRL, d);   chk("R10 control readback", d, 8'h03);
        chk("R3 kb_ready high", kb_ready, 1);
        bus_read(A_STAT, d);   chk("R9 display request", d, 8'h0A);
        chk("R9 irq from display", irq, 1);
    endtask

    task automatic t_kb_basic();
        logic [7:0] d;
        kb_send(8'h41);
        bus_read(A_STAT, d);   chk("R3 in ready set", d, 8'h0F);
        bus_read(A_KIN, d);    chk("R4 data read", d, 8'h41);
        bus_read(A_STAT, d);   chk("R4 flag cleared", d, 8'h0A);
    endtask

    task automatic t_overrun();
        logic [7:0] d;
        kb_send(8'h42);
        kb_send(8'h43);
        bus_read(A_STAT, d);   chk("R5 overrun set", d, 8'h1F);
        bus_read(A_KIN, d);    chk("R5 first kept", d, 8'h42);
        bus_read(A_STAT, d);   chk("R5 overrun sticky", d, 8'h1A);
        bus_write(A_STAT, 8'h0F);
        bus_read(A_STAT, d);   chk("R5 clear needs bit4", d, 8'h1A);
        bus_write(A_STAT, 8'h10);
        bus_read(A_STAT, d);   chk("R5 overrun cleared", d, 8'h0A);
    endtask

    task automatic t_read_and_arrive();
        logic [7:0] d;
        kb_send(8'h50);
        @(negedge clk);
        bus_addr = A_KIN; bus_rd = 1'b1; kb_char = 8'h51; kb_valid = 1'b1;
        #1 d = bus_rdata;
        chk("R4 same-cycle read old", d, 8'h50);
        @(negedge clk);
        bus_rd = 1'b0; kb_valid = 1'b0;
        bus_read(A_STAT, d);   chk("R4 same-cycle flag kept", d, 8'h0F);
        bus_read(A_KIN, d);    chk("R4 same-cycle new data", d, 8'h51);
    endtask

    task automatic t_output();
        logic [7:0] d;
        bus_write(A_DOUT, 8'h5A);
        bus_read(A_STAT, d);   chk("R7 out ready cleared", d, 8'h00);
        chk("R9 irq low", irq, 0);
        chk("R8 dp_valid", dp_valid, 1);
        chk("R8 dp_char", dp_char, 8'h5A);
        bus_write(A_DOUT, 8'h66);
        chk("R7 write while full ignored", dp_char, 8'h5A);
        dp_take(d);            chk("R8 taken char", d, 8'h5A);
        chk("R8 dp_valid low", dp_valid, 0);
        bus_read(A_STAT, d);   chk("R8 out ready set", d, 8'h0A);
    endtask

    task automatic t_disp_disabled();
        logic [7:0] d;
        bus_write(A_CTRL, 8'h01);
        bus_write(A_DOUT, 8'h33);
        chk("R8 held while disabled", dp_valid, 0);
        dp_take(d);
        bus_read(A_STAT, d);   chk("R8 no drain while disabled", d, 8'h00);
        bus_write(A_CTRL, 8'h03);
        chk("R8 valid after enable", dp_valid, 1);
        chk("R8 char after enable", dp_char, 8'h33);
        dp_take(d);
        bus_read(A_STAT, d);   chk("R9 after drain", d, 8'h0A);
    endtask

    task automatic t_decode();
        logic [7:0] d;
        kb_send(8'h77);
        bus_read(A_MISS, d);         chk("R1 miss reads zero", d, 8'h00);
        bus_read(16'h1F40, d);       chk("R1 upper miss reads zero", d, 8'h00);
        bus_read(A_STAT, d);         chk("R1 miss no side effect", d, 8'h0F);
        bus_write(16'h0F5C, 8'h00);
        bus_read(A_CTRL, d);         chk("R1 miss write ignored", d, 8'h03);
        bus_write(A_KIN, 8'h99);
        bus_read(A_DOUT, d);         chk("R11 read of offset 4", d, 8'h00);
        bus_read(A_STAT, d);         chk("R11 status untouched", d, 8'h0F);
        bus_write(A_CTRL, 8'h00);
        chk("R9 irq gated off", irq, 0);
        bus_read(A_STAT, d);         chk("R9 requests gated", d, 8'h03);
        bus_read(A_KIN, d);          chk("R11 data unchanged by write", d, 8'h77);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_kb_disabled();
        t_enable();
        t_kb_basic();
        t_overrun();
        t_read_and_arrive();
        t_output();
        t_disp_disabled();
        t_decode();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule